// File: doc/BRIEF.md
# Four-Phase Fractional Clock Divider

This block derives a roughly 48 MHz clock enable from a faster system clock. It steps through four phases in turn, and each phase counts its own integer divide ratio. Each ratio is picked by a 3-bit code from the set 6 to 11. Because the four phase periods can differ, the long-run average ratio is the mean of the four, which need not be an integer. The output is a one-cycle tick that marks the end of each phase period.

A second path lets an external 48 MHz source stand in for the divider. A select input picks which source drives the selected clock output. When the external source is chosen, a second input decides whether it passes through a two-flop synchronizer in the system clock domain or goes straight through.

The divider only runs while its enable is high. Dropping the enable clears the counter and returns the phase pointer to the first phase.

Top module: `frac_clk_gen`

## Requirements
- R1: The 3-bit code of a phase sets that phase's divide ratio: code 3'b110 gives 6, 3'b111 gives 7, 3'b000 gives 8, 3'b001 gives 9, 3'b010 gives 10 and 3'b011 gives 11. The code for phase k sits at bits [3k+2:3k] of `ratioCodes`.
- R2: Codes 3'b100 and 3'b101 also give a ratio of 11, so three codes in all give divide-by-11.
- R3: While enabled, the phases run in the order 0, 1, 2, 3 and then wrap to 0. The gap between two ticks, counted in clock cycles, equals the ratio of the phase that ends at the later tick.
- R4: While `divEn` is low, `outTick` stays low from the first clock edge after it falls. The next enable starts again at phase 0.
- R5: If `divEn` is first sampled high at a clock edge E after being low, the first `outTick` is high for one cycle, starting at edge E+N0-1, where N0 is the ratio of phase 0.
- R6: A phase's code is sampled only when that phase loads. A change during a running phase leaves the current period unchanged and takes effect the next time that phase starts.
- R7: When `extSel` is 0, `selClk` follows `outTick`.
- R8: When `extSel` is 1 and `syncEn` is 0, `selClk` follows `extClkIn` with no register in the path.
- R9: When `extSel` is 1 and `syncEn` is 1, `selClk` equals the value `extClkIn` had two clock edges earlier.
- R10: After reset, `outTick` is 0 and both synchronizer flops hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divEn | input | 1 | Divider run enable |
| ratioCodes | input | 12 | Four 3-bit phase ratio codes, phase k at bits [3k+2:3k] |
| extSel | input | 1 | 1 selects the external 48 MHz source, 0 selects the divider |
| syncEn | input | 1 | 1 routes the external source through the synchronizer |
| extClkIn | input | 1 | External 48 MHz source |
| outTick | output | 1 | One-cycle divider tick at the end of each phase |
| selClk | output | 1 | Selected 48 MHz clock indication |

## Verification
The tick-gap assertion assumes that `divEn` stays high between the two ticks it compares. Its checker drops the measurement whenever the enable goes low, and the stimulus changes codes freely only while the enable is high. The synchronizer-latency property assumes at least two edges since reset, and the checker counts those edges itself. `extClkIn` is driven only away from the active edge, so each value the synchronizer captures is unambiguous. The sweep places every code in every phase position and measures each tick gap, so the decode and the phase order are both checked.

// File: rtl/fcg_pkg.sv
package fcg_pkg;

  localparam int CODE_W = 3;
  localparam int CNT_W  = 4;

  typedef struct packed {
    logic clear;
    logic load;
    logic dec;
  } ctrlStrobe_t;

  // Partial decode: 11x -> 6/7, 10x -> 11, 0xx -> 8..11
  function automatic logic [CNT_W-1:0] decodeRatio(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] r;
    if (code[2] && code[1])
      r = CNT_W'(6) + CNT_W'(code[0]);
    else if (code[2])
      r = CNT_W'(11);
    else
      r = CNT_W'(8) + CNT_W'(code[1:0]);
    return r;
  endfunction

endpackage

// File: rtl/fcg_ctrl.sv
module fcg_ctrl
  import fcg_pkg::*;
#(
  parameter int PHASES = 4,
  localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            divEn,
  input  logic            cntZero,
  output ctrlStrobe_t     strobe,
  output logic [PH_W-1:0] loadPhase,
  output logic            outTick
);

  logic            active;
  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] nextPhase;

  assign nextPhase = (phase == PH_W'(PHASES - 1)) ? '0 : phase + PH_W'(1);

  always_comb begin
    strobe    = '0;
    loadPhase = nextPhase;
    if (!divEn) begin
      strobe.clear = 1'b1;
    end else if (!active) begin
      strobe.load = 1'b1;
      loadPhase   = '0;
    end else if (cntZero) begin
      strobe.load = 1'b1;
    end else begin
      strobe.dec = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      active <= 1'b0;
      phase  <= '0;
    end else if (strobe.load) begin
      active <= 1'b1;
      phase  <= loadPhase;
    end
  end

  assign outTick = active && cntZero;

endmodule

// File: rtl/fcg_datapath.sv
module fcg_datapath
  import fcg_pkg::*;
#(
  parameter int PHASES      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int PH_W   = (PHASES > 1) ? $clog2(PHASES) : 1,
  localparam int CODES_W = PHASES * CODE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [PH_W-1:0]    loadPhase,
  input  logic [CODES_W-1:0] ratioCodes,
  input  logic               extClkIn,
  output logic               cntZero,
  output logic               extSynced
);

  logic [CNT_W-1:0] decoded [PHASES];
  logic [CNT_W-1:0] cnt;
  logic [SYNC_STAGES-1:0] syncReg;

  for (genvar g = 0; g < PHASES; g++) begin : g_dec
    assign decoded[g] = decodeRatio(ratioCodes[g*CODE_W +: CODE_W]);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear)
      cnt <= '0;
    else if (strobe.load)
      cnt <= decoded[loadPhase] - CNT_W'(1);
    else if (strobe.dec)
      cnt <= cnt - CNT_W'(1);
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) syncReg <= '0;
    else       syncReg <= {syncReg[SYNC_STAGES-2:0], extClkIn};
  end

  assign extSynced = syncReg[SYNC_STAGES-1];

endmodule

// File: rtl/frac_clk_gen.sv
module frac_clk_gen
  import fcg_pkg::*;
#(
  parameter int PHASES      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int PH_W    = (PHASES > 1) ? $clog2(PHASES) : 1,
  localparam int CODES_W = PHASES * CODE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               divEn,
  input  logic [CODES_W-1:0] ratioCodes,
  input  logic               extSel,
  input  logic               syncEn,
  input  logic               extClkIn,
  output logic               outTick,
  output logic               selClk
);

  ctrlStrobe_t     strobe;
  logic [PH_W-1:0] loadPhase;
  logic            cntZero;
  logic            extSynced;

  fcg_ctrl #(.PHASES(PHASES)) u_ctrl (
    .clk(clk), .rstN(rstN), .divEn(divEn), .cntZero(cntZero),
    .strobe(strobe), .loadPhase(loadPhase), .outTick(outTick)
  );

  fcg_datapath #(.PHASES(PHASES), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadPhase(loadPhase),
    .ratioCodes(ratioCodes), .extClkIn(extClkIn),
    .cntZero(cntZero), .extSynced(extSynced)
  );

  always_comb begin
    if (!extSel)     selClk = outTick;
    else if (syncEn) selClk = extSynced;
    else             selClk = extClkIn;
  end

endmodule

// File: rtl/fcg_checker.sv
module fcg_checker (
  input logic clk,
  input logic rstN,
  input logic divEn,
  input logic extSel,
  input logic syncEn,
  input logic extClkIn,
  input logic outTick,
  input logic selClk
);

  logic [4:0] since;
  logic       gapValid;
  logic [1:0] edgesSinceRst;

  always_ff @(posedge clk) begin
    if (!rstN || !divEn) begin
      since    <= '0;
      gapValid <= 1'b0;
    end else if (outTick) begin
      since    <= 5'd1;
      gapValid <= 1'b1;
    end else if (since != 5'd31) begin
      since <= since + 5'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) edgesSinceRst <= '0;
    else if (edgesSinceRst != 2'd3) edgesSinceRst <= edgesSinceRst + 2'd1;
  end

  p_no_tick_disabled_r4: assert property (@(posedge clk) disable iff (!rstN)
    !divEn |=> !outTick);

  p_tick_one_cycle_r5: assert property (@(posedge clk) disable iff (!rstN)
    outTick |=> !outTick);

  p_gap_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outTick && gapValid && divEn) |-> (since >= 5'd6 && since <= 5'd11));

  p_sync_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    (extSel && syncEn && edgesSinceRst >= 2'd2) |-> (selClk == $past(extClkIn, 2)));

endmodule

bind frac_clk_gen fcg_checker u_chk (
  .clk(clk), .rstN(rstN), .divEn(divEn), .extSel(extSel), .syncEn(syncEn),
  .extClkIn(extClkIn), .outTick(outTick), .selClk(selClk)
);

// File: tb/sim_frac_clk_gen.sv
module sim_frac_clk_gen;

  logic        clk = 1'b0;
  logic        rstN;
  logic        divEn;
  logic [11:0] ratioCodes;
  logic        extSel;
  logic        syncEn;
  logic        extClkIn;
  logic        outTick;
  logic        selClk;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  frac_clk_gen u0 (
    .clk(clk), .rstN(rstN), .divEn(divEn), .ratioCodes(ratioCodes),
    .extSel(extSel), .syncEn(syncEn), .extClkIn(extClkIn),
    .outTick(outTick), .selClk(selClk)
  );

  function automatic int expRatio(input logic [2:0] c);
    case (c)
      3'b110: return 6;
      3'b111: return 7;
      3'b000: return 8;
      3'b001: return 9;
      3'b010: return 10;
      default: return 11;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Enable with given codes, record 7 tick times, check first tick and gaps
  task automatic runCfg(input logic [11:0] codes);
    int t[7];
    int n = 0;
    int k = 0;
    @(negedge clk);
    ratioCodes = codes;
    divEn = 1'b1;
    while (n < 7 && k < 200) begin
      @(negedge clk);
      k++;
      if (outTick) begin
        t[n] = k;
        if (n == 0) chk("R7 selClk follows tick", int'(selClk), 1);
        n++;
      end
    end
    chk("R5 tick count", n, 7);
    if (n == 7) begin
      chk("R5/R1/R2 first tick", t[0], expRatio(codes[2:0]));
      for (int i = 1; i < 7; i++) begin
        int ph = i % 4;
        chk($sformatf("R3/R1/R2 gap phase %0d", ph), t[i] - t[i-1],
            expRatio(codes[ph*3 +: 3]));
      end
    end
    divEn = 1'b0;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      chk("R4 no tick while disabled", int'(outTick), 0);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
      finishRun();
    end
  end

  initial begin
    int hist[64];
    int k;
    rstN = 1'b0; divEn = 1'b0; ratioCodes = '0;
    extSel = 1'b0; syncEn = 1'b0; extClkIn = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    extClkIn = 1'b0;
    extSel = 1'b1; syncEn = 1'b1;
    @(negedge clk);
    // R10: synchronizer flops hold 0 after reset, tick low
    chk("R10 tick after reset", int'(outTick), 0);
    chk("R10 sync output after reset", int'(selClk), 0);
    extSel = 1'b0; syncEn = 1'b0;

    // Sweep: every code in every phase position
    for (int c = 0; c < 8; c++) begin
      logic [2:0] a = 3'(c);
      logic [2:0] b = 3'(c + 1);
      logic [2:0] d = 3'(c + 3);
      logic [2:0] e = 3'(c + 5);
      runCfg({e, d, b, a});
    end

    // R6: change codes in the middle of phase 0
    @(negedge clk);
    ratioCodes = {4{3'b000}};
    divEn = 1'b1;
    begin
      int t[3];
      int n = 0;
      k = 0;
      while (n < 3 && k < 100) begin
        @(negedge clk);
        k++;
        if (k == 3) ratioCodes = {4{3'b110}};
        if (outTick) begin t[n] = k; n++; end
      end
      chk("R6 ticks seen", n, 3);
      if (n == 3) begin
        chk("R6 current period kept", t[0], 8);
        chk("R6 new code at next phase", t[1] - t[0], 6);
        chk("R6 new code persists", t[2] - t[1], 6);
      end
    end

    // R4: disable mid-phase, re-enable restarts at phase 0
    @(negedge clk);
    ratioCodes = {3'b011, 3'b011, 3'b011, 3'b110};
    divEn = 1'b0;
    @(negedge clk);
    divEn = 1'b1;
    k = 0;
    while (!outTick && k < 50) begin @(negedge clk); k++; end
    repeat (3) @(negedge clk);
    divEn = 1'b0;
    @(negedge clk);
    chk("R4 tick cleared on disable", int'(outTick), 0);
    @(negedge clk);
    divEn = 1'b1;
    k = 0;
    while (k < 50) begin
      @(negedge clk);
      k++;
      if (outTick) break;
    end
    chk("R4 restart at phase 0", k, 6);
    @(negedge clk);
    divEn = 1'b0;
    repeat (2) @(negedge clk);

    // R8: external source unsynchronized, combinational
    extSel = 1'b1; syncEn = 1'b0;
    for (int i = 0; i < 8; i++) begin
      extClkIn = logic'((i * 5 + 1) % 3 == 0);
      #1;
      chk("R8 raw external", int'(selClk), int'(extClkIn));
      @(negedge clk);
    end

    // R9: synchronized external source, two-edge latency
    syncEn = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if (i >= 2)
        chk("R9 two-edge latency", int'(selClk), hist[i-2]);
      hist[i] = ((i * 7 + 3) % 5) < 2 ? 1 : 0;
      extClkIn = logic'(hist[i]);
      @(negedge clk);
    end

    // R7: divider path selected, selClk low when no tick
    extSel = 1'b0; syncEn = 1'b1; extClkIn = 1'b1;
    @(negedge clk);
    chk("R7 selClk idle follows tick", int'(selClk), int'(outTick));

    done = 1;
    finishRun();
  end

endmodule